// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block carries out the count-and-branch loop primitive of a small processor core. A requester presents an 8-bit postbyte, an 8-bit offset byte and the program counter value that follows both bytes. The unit reads the selected register through a read port. It decrements it, increments it or leaves it as it is. It tests the result against zero and decides whether the loop branch is taken. It also forms the branch target from the program counter and a 9-bit signed displacement.

The result goes back through a write strobe on the register file port. A taken branch is reported as a one-cycle PC load strobe together with the target. Each operation is bounded by a four-phase request/acknowledge exchange. The requester raises `req` and holds its inputs. The unit answers with a single-cycle `ack`, and the two strobes and the illegal flag are valid in that same cycle. The unit accepts no new work until `req` has been dropped.

Postbyte layout: bits 7:6 are the operation (00 count down, 01 test only, 10 count up, 11 reserved). Bit 5 is the branch sense. Bit 4 is the sign of the displacement. Bits 2:0 select the register (0 A, 1 B, 2 CCR, 3 scratch, 4 D, 5 X, 6 Y, 7 SP).

Top module: `lcb_unit`

## Requirements
- R1: When `req` is sampled high in idle, `ack` is high for exactly one cycle, on the second rising edge after that sample. No second `ack` follows until `req` has been seen low.
- R2: Operation 00 (bits 7:6) writes the register value minus one back to the same register, with `rf_wr_en` high in the `ack` cycle.
- R3: Operation 10 writes the register value plus one back to the same register in the `ack` cycle.
- R4: Operation 01 leaves `rf_wr_en` low and tests the unmodified register value.
- R5: With postbyte bit 5 set, the branch is taken when the result is nonzero. With bit 5 clear, it is taken when the result is zero.
- R6: Postbyte bits 2:0 drive `rf_rd_sel`, and a write-back goes to that same index.
- R7: `pc_target` equals `pc_in` plus the sign extension of the 9-bit value {postbyte bit 4, `offset`}, modulo 2^16.
- R8: For registers 0 and 1, counting and the zero test use only bits 7:0, wrapping within 8 bits, and the written value has bits 15:8 zero.
- R9: Operation 11 sets `illegal_op` in the `ack` cycle, with neither `rf_wr_en` nor `pc_load`.
- R10: After reset, `ack`, `rf_wr_en`, `pc_load` and `illegal_op` are low.
- R11: `pc_load` is high in the `ack` cycle exactly when the branch is taken, and never outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Operation request, held until after `ack` |
| ack | output | 1 | One-cycle completion pulse |
| postbyte | input | 8 | Operation, sense, offset sign and register select |
| offset | input | 8 | Low byte of the displacement |
| pc_in | input | 16 | PC following the two operand bytes |
| rf_rd_sel | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data, combinational |
| rf_wr_en | output | 1 | Write-back strobe |
| rf_wr_sel | output | 3 | Write-back index |
| rf_wr_data | output | 16 | Write-back value |
| pc_load | output | 1 | Branch-taken strobe |
| pc_target | output | 16 | Branch target |
| illegal_op | output | 1 | Reserved operation code seen |

## Verification
The checker relies on the requester holding `postbyte`, `offset` and `pc_in` steady from raising `req` until after `ack`. It also relies on the register file returning read data in the same cycle as the index. The test-only property and the handshake properties depend on both. The bench drives each request at a falling edge and keeps every input fixed until it has seen `ack` and one further cycle. Its register file model answers reads combinationally from its own array and takes writes only on the write strobe.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

    // Register select field width is fixed by the postbyte layout.
    localparam int SEL_W = 3;
    localparam int PB_W  = 8;

    typedef enum logic [1:0] {
        OP_DEC = 2'b00,
        OP_TST = 2'b01,
        OP_INC = 2'b10,
        OP_RSV = 2'b11
    } lcb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2,
        ST_HOLD = 2'd3
    } lcb_state_e;

endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
    import lcb_pkg::*;
#(
    parameter int NARROW_REGS = 2
) (
    input  logic [PB_W-1:0]  pb,
    output lcb_op_e          op,
    output logic             sense_nz,
    output logic             off_sign,
    output logic [SEL_W-1:0] sel,
    output logic             narrow
);
    logic unused_pb3;

    assign op         = lcb_op_e'(pb[7:6]);
    assign sense_nz   = pb[5];
    assign off_sign   = pb[4];
    assign unused_pb3 = pb[3];
    assign sel        = pb[SEL_W-1:0];
    assign narrow     = (32'(sel) < NARROW_REGS);
endmodule

// File: rtl/lcb_count.sv
module lcb_count
    import lcb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  lcb_op_e           op,
    input  logic              narrow,
    input  logic              sense_nz,
    input  logic [DATA_W-1:0] val,
    output logic [DATA_W-1:0] res,
    output logic              wr_req,
    output logic              take,
    output logic              bad
);
    logic [DATA_W-1:0] wide_res;
    logic              is_zero;

    always_comb begin
        unique case (op)
            OP_DEC:  wide_res = val - 1'b1;
            OP_INC:  wide_res = val + 1'b1;
            default: wide_res = val;
        endcase
    end

    generate
        if (NARROW_W < DATA_W) begin : g_narrow
            logic [NARROW_W-1:0] n_val;
            logic [NARROW_W-1:0] n_res;
            assign n_val = val[NARROW_W-1:0];
            always_comb begin
                unique case (op)
                    OP_DEC:  n_res = n_val - 1'b1;
                    OP_INC:  n_res = n_val + 1'b1;
                    default: n_res = n_val;
                endcase
            end
            assign res = narrow ? {{(DATA_W-NARROW_W){1'b0}}, n_res} : wide_res;
        end else begin : g_wide
            logic unused_narrow;
            assign unused_narrow = narrow;
            assign res = wide_res;
        end
    endgenerate

    assign is_zero = (res == '0);
    assign bad     = (op == OP_RSV);
    assign wr_req  = (op == OP_DEC) || (op == OP_INC);
    assign take    = !bad && (sense_nz ? !is_zero : is_zero);
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             sign,
    input  logic [OFF_W-1:0] off,
    output logic [PC_W-1:0]  target
);
    localparam int EXT_W = PC_W - OFF_W - 1;

    logic [PC_W-1:0] disp;

    assign disp   = {{EXT_W{sign}}, sign, off};
    assign target = pc + disp;
endmodule

// File: rtl/lcb_unit.sv
module lcb_unit
    import lcb_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int PC_W        = 16,
    parameter int OFF_W       = 8,
    parameter int NARROW_W    = 8,
    parameter int NARROW_REGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              ack,
    input  logic [PB_W-1:0]   postbyte,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PC_W-1:0]   pc_in,
    output logic [SEL_W-1:0]  rf_rd_sel,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [SEL_W-1:0]  rf_wr_sel,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_target,
    output logic              illegal_op
);
    typedef struct packed {
        lcb_state_e        st;
        logic [PB_W-1:0]   pb;
        logic [OFF_W-1:0]  off;
        logic [PC_W-1:0]   pc;
        logic              ack;
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;
        logic              load;
        logic [PC_W-1:0]   tgt;
        logic              bad;
    } lcb_regs_t;

    lcb_regs_t s_d, s_q;

    lcb_op_e           dec_op;
    logic              dec_sense_nz;
    logic              dec_sign;
    logic [SEL_W-1:0]  dec_sel;
    logic              dec_narrow;
    logic [DATA_W-1:0] cnt_res;
    logic              cnt_wr;
    logic              cnt_take;
    logic              cnt_bad;
    logic [PC_W-1:0]   tgt_calc;

    lcb_decode #(.NARROW_REGS(NARROW_REGS)) u_decode (
        .pb       (s_q.pb),
        .op       (dec_op),
        .sense_nz (dec_sense_nz),
        .off_sign (dec_sign),
        .sel      (dec_sel),
        .narrow   (dec_narrow)
    );

    lcb_count #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_count (
        .op       (dec_op),
        .narrow   (dec_narrow),
        .sense_nz (dec_sense_nz),
        .val      (rf_rd_data),
        .res      (cnt_res),
        .wr_req   (cnt_wr),
        .take     (cnt_take),
        .bad      (cnt_bad)
    );

    lcb_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc     (s_q.pc),
        .sign   (dec_sign),
        .off    (s_q.off),
        .target (tgt_calc)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ack   = 1'b0;
        s_d.wr_en = 1'b0;
        s_d.load  = 1'b0;
        s_d.bad   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.pb  = postbyte;
                    s_d.off = offset;
                    s_d.pc  = pc_in;
                    s_d.st  = ST_READ;
                end
            end
            ST_READ: begin
                s_d.ack     = 1'b1;
                s_d.wr_en   = cnt_wr;
                s_d.wr_data = cnt_res;
                s_d.load    = cnt_take;
                s_d.tgt     = tgt_calc;
                s_d.bad     = cnt_bad;
                s_d.st      = ST_DONE;
            end
            ST_DONE: begin
                s_d.st = ST_HOLD;
            end
            default: begin
                if (!req) begin
                    s_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ack        = s_q.ack;
    assign rf_rd_sel  = dec_sel;
    assign rf_wr_en   = s_q.wr_en;
    assign rf_wr_sel  = dec_sel;
    assign rf_wr_data = s_q.wr_data;
    assign pc_load    = s_q.load;
    assign pc_target  = s_q.tgt;
    assign illegal_op = s_q.bad;
endmodule

// File: rtl/lcb_unit_chk.sv
module lcb_unit_chk
    import lcb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PC_W     = 16,
    parameter int OFF_W    = 8,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ack,
    input logic [PB_W-1:0]   postbyte,
    input logic [OFF_W-1:0]  offset,
    input logic [PC_W-1:0]   pc_in,
    input logic [SEL_W-1:0]  rf_rd_sel,
    input logic [DATA_W-1:0] rf_rd_data,
    input logic              rf_wr_en,
    input logic [SEL_W-1:0]  rf_wr_sel,
    input logic [DATA_W-1:0] rf_wr_data,
    input logic              pc_load,
    input logic [PC_W-1:0]   pc_target,
    input logic              illegal_op
);
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R1
    AST_ACK_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> req); // R1
    AST_WRITE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> ack); // R2
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && postbyte[7:6] == 2'b01) |-> !rf_wr_en); // R4
    AST_SAME_REG: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (rf_wr_sel == rf_rd_sel)); // R6
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && rf_wr_sel < 3'd2) |-> (rf_wr_data[DATA_W-1:NARROW_W] == '0)); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (ack && !rf_wr_en && !pc_load)); // R9
    AST_LOAD_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ack); // R11
endmodule

bind lcb_unit lcb_unit_chk #(
    .DATA_W(DATA_W), .PC_W(PC_W), .OFF_W(OFF_W), .NARROW_W(NARROW_W)
) u_chk (.*);

// File: tb/lcb_unit_bench.sv
module lcb_unit_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        ack;
    logic [7:0]  postbyte = '0;
    logic [7:0]  offset = '0;
    logic [15:0] pc_in = '0;
    logic [2:0]  rf_rd_sel;
    logic [15:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_sel;
    logic [15:0] rf_wr_data;
    logic        pc_load;
    logic [15:0] pc_target;
    logic        illegal_op;

    logic [15:0] bregs [8];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcb_unit u_lcb_unit (
        .clk, .rst_n, .req, .ack, .postbyte, .offset, .pc_in,
        .rf_rd_sel, .rf_rd_data, .rf_wr_en, .rf_wr_sel, .rf_wr_data,
        .pc_load, .pc_target, .illegal_op
    );

    assign rf_rd_data = bregs[rf_rd_sel];

    always @(posedge clk) begin
        if (rf_wr_en) bregs[rf_wr_sel] <= rf_wr_data;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Runs one operation and checks every output against an independent model.
    task automatic run_op(input string tag, input logic [7:0] pb, input logic [7:0] off,
                          input logic [15:0] pc);
        logic [1:0]  op;
        logic [2:0]  sel;
        logic [15:0] v, r, tgt;
        logic [7:0]  v8, r8;
        logic        zero, take, wr, bad;
        int n;
        op  = pb[7:6];
        sel = pb[2:0];
        v   = bregs[sel];
        if (sel < 3'd2) begin
            v8 = v[7:0];
            r8 = (op == 2'b00) ? v8 - 8'd1 : (op == 2'b10) ? v8 + 8'd1 : v8;
            r  = {8'h00, r8};
        end else begin
            r = (op == 2'b00) ? v - 16'd1 : (op == 2'b10) ? v + 16'd1 : v;
        end
        zero = (r == 16'd0);
        bad  = (op == 2'b11);
        take = !bad && (pb[5] ? !zero : zero);
        wr   = (op == 2'b00) || (op == 2'b10);
        tgt  = pc + {{7{pb[4]}}, pb[4], off};

        @(negedge clk);
        postbyte = pb; offset = off; pc_in = pc; req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ack && n < 20);
        chk({tag, " R1 latency"}, n, 2);
        chk({tag, " R6 read sel"}, rf_rd_sel, sel);
        chk({tag, " R2/R3/R4 write strobe"}, rf_wr_en, wr);
        if (wr) begin
            chk({tag, " R6 write sel"}, rf_wr_sel, sel);
            chk({tag, " R2/R3/R8 write data"}, rf_wr_data, r);
        end
        chk({tag, " R11 pc_load"}, pc_load, take);
        if (take) chk({tag, " R7 target"}, pc_target, tgt);
        chk({tag, " R9 illegal"}, illegal_op, bad);
        @(negedge clk);
        chk({tag, " R1 single pulse"}, ack, 0);
        @(negedge clk);
        chk({tag, " R1 no rerun while req held"}, ack, 0);
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 ack", ack, 0);
        chk("R10 wr_en", rf_wr_en, 0);
        chk("R10 pc_load", pc_load, 0);
        chk("R10 illegal", illegal_op, 0);
    endtask

    task automatic t_count_down();
        bregs[5] = 16'h0001;
        run_op("R2 dec X to zero, R5 branch on zero", 8'h05, 8'h10, 16'h1000);
        chk("R2 X after", bregs[5], 16'h0000);
        run_op("R2 dec X wrap, R5 zero sense not taken", 8'h05, 8'h10, 16'h1000);
        chk("R2 X wrapped", bregs[5], 16'hFFFF);
    endtask

    task automatic t_count_up();
        bregs[6] = 16'h7FFF;
        run_op("R3 inc Y, R5 nonzero sense", 8'hA6, 8'h22, 16'h3000);
        chk("R3 Y after", bregs[6], 16'h8000);
    endtask

    task automatic t_test_only();
        bregs[4] = 16'h0000;
        run_op("R4 test D nonzero sense", 8'h64, 8'h05, 16'h0400);
        chk("R4 D untouched", bregs[4], 16'h0000);
        bregs[7] = 16'h0000;
        run_op("R4 test SP zero sense", 8'h47, 8'h7F, 16'h0400);
        chk("R4 SP untouched", bregs[7], 16'h0000);
    endtask

    task automatic t_narrow();
        bregs[0] = 16'h1200;
        run_op("R8 test A low byte zero", 8'h40, 8'h01, 16'h0100);
        run_op("R8 dec A wraps in 8 bits", 8'h00, 8'h01, 16'h0100);
        chk("R8 A after", bregs[0], 16'h00FF);
        bregs[1] = 16'h34FF;
        run_op("R8 inc B wraps to zero", 8'h81, 8'h02, 16'h0200);
        chk("R8 B after", bregs[1], 16'h0000);
    endtask

    task automatic t_backward();
        bregs[5] = 16'h0001;
        run_op("R7 negative displacement", 8'h15, 8'hF0, 16'h2000);
        run_op("R7 wrap below zero", 8'hB2, 8'h00, 16'h0010);
    endtask

    task automatic t_reserved();
        bregs[3] = 16'h0000;
        run_op("R9 reserved op", 8'hC3, 8'h08, 16'h0500);
        chk("R9 register untouched", bregs[3], 16'h0000);
    endtask

    task automatic t_all_regs();
        for (int i = 0; i < 8; i++) begin
            bregs[i] = 16'h0100 + 16'(i);
            run_op("R6 register sweep", {5'b00100, 3'(i)}, 8'h04, 16'h0800);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) bregs[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_count_down();
        t_count_up();
        t_test_only();
        t_narrow();
        t_backward();
        t_reserved();
        t_all_regs();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end
endmodule